// File: doc/BRIEF.md
# Two-Stage Register-ALU Execution Pipeline

This block executes a stream of three-register ALU instructions in two clocked stages. In the first stage, an accepted instruction reads its two source registers from a register file that has two read ports and one write port. In the second stage, the ALU computes the result, and the result is written to the destination register at the end of that cycle. Because the stages overlap, the operand read of one instruction happens in the same cycle as the ALU work and the write-back of the instruction before it.

Instructions enter through a valid/ready handshake. Back-pressure follows these rules:
- An instruction is taken on a rising edge where `in_valid` and `in_ready` are both high.
- Once the producer raises `in_valid`, it must keep `in_valid` high and hold every instruction field stable until that edge.
- `in_ready` is low only during an interlock stall.

The write-back port is an observation stream. It carries no ready signal and cannot be stalled.

The `BYPASS` parameter chooses how the block resolves a read-after-write conflict with the instruction in stage 2:
- **Forwarding (`BYPASS` = 1):** the ALU output is steered into the matching operand. No cycle is lost.
- **Interlock (`BYPASS` = 0):** issue is held for one cycle until the producer's value is in the register file.

A saturation-free wrapping counter reports the number of stall cycles.

Top module: `dual_stage_exec`

## Requirements
- R1: After reset, `in_ready` is 1, `wb_valid` is 0, `stall_count` is 0 and every register reads as zero.
- R2: The `in_op` code selects the result, which wraps modulo 2^DATA_W:
  - 0: A+B
  - 1: A−B
  - 2: A AND B
  - 3: A OR B
  - 4: A XOR B
  - 5: `in_imm`
  - 6: A
  - 7: NOR of A and B
  
  Here A and B are the values of registers `in_src_a` and `in_src_b`.
- R3: An instruction accepted on edge k appears on `wb_valid`/`wb_dst`/`wb_data` during the cycle after edge k. Independent instructions are accepted one per clock.
- R4: A source that names the destination of an instruction accepted two or more cycles earlier reads that instruction's result, with no stall.
- R5: With `BYPASS`=1, a source equal to the stage-2 destination receives the stage-2 result, on either or both operands. `in_ready` never drops.
- R6: With `BYPASS`=0, that same conflict holds `in_ready` low for exactly one cycle. The instruction is then accepted and sees the new value.
- R7: `stall_count` increases by one in each cycle with `in_valid`=1 and `in_ready`=0, and holds otherwise. With `BYPASS`=1 it stays 0.
- R8: A cycle with no accepted instruction puts a bubble in stage 2. The bubble gives `wb_valid`=0 and writes no register.
- R9: A source field that the op does not use never causes a conflict. Op 5 uses neither source, and op 6 does not use B.
- R10: During a stall, the held instruction is executed once, with its held fields, when it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can take the instruction this cycle |
| in_op | input | 3 | Operation code (see R2) |
| in_dst | input | log2(NREG) | Destination register |
| in_src_a | input | log2(NREG) | First source register |
| in_src_b | input | log2(NREG) | Second source register |
| in_imm | input | DATA_W | Immediate for op 5 |
| wb_valid | output | 1 | Stage 2 holds an instruction that is writing this cycle |
| wb_dst | output | log2(NREG) | Register being written |
| wb_data | output | DATA_W | Value being written |
| stall_count | output | CNT_W | Stall cycles since reset, wrapping |

## Verification
The hardest case to bring about is a conflict that arrives exactly one cycle after its producer was accepted. A gap of even one idle cycle lets the register file absorb the value, and the conflict path is never exercised. The driver therefore presents each instruction on the clock that follows the previous acceptance. The stimulus includes:
- dependent pairs on operand A, on operand B and on both;
- a chain of three self-dependent additions;
- unused source fields that alias the previous destination.

Separate instances for the forwarding and interlock variants run the same program. The bench predicts the exact stall count of each instruction from the acceptance cycles.

// File: rtl/dsx_pkg.sv
package dsx_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_LDI  = 3'd5,
    OP_PASS = 3'd6,
    OP_NOR  = 3'd7
  } dsx_op_e;

  // operand A is consumed by every op except the immediate load
  function automatic logic op_reads_a(input logic [2:0] op);
    return (op != 3'(OP_LDI));
  endfunction

  // operand B is ignored by the immediate load and the copy
  function automatic logic op_reads_b(input logic [2:0] op);
    return (op != 3'(OP_LDI)) && (op != 3'(OP_PASS));
  endfunction

endpackage

// File: rtl/dsx_regfile.sv
module dsx_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr [2],
  output logic [DATA_W-1:0] rd_data [2],
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] regs [NREG];

  // write lands on the clock edge: a same-cycle read sees the old value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rd_data[p] = regs[rd_addr[p]];
  end

endmodule

// File: rtl/dsx_hazard.sv
module dsx_hazard #(
  parameter int NREG   = 8,
  parameter int BYPASS = 1,
  localparam int AW    = $clog2(NREG)
) (
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic          s2_valid,
  input  logic [AW-1:0] s2_dst,
  output logic          hit_a,
  output logic          hit_b,
  output logic          stall
);
  import dsx_pkg::*;

  localparam bit HOLD_ISSUE = (BYPASS == 0);

  assign hit_a = s2_valid && op_reads_a(in_op) && (src_a == s2_dst);
  assign hit_b = s2_valid && op_reads_b(in_op) && (src_b == s2_dst);
  assign stall = HOLD_ISSUE && in_valid && (hit_a || hit_b);

endmodule

// File: rtl/dsx_alu.sv
module dsx_alu #(
  parameter int DATA_W = 16
) (
  input  dsx_pkg::dsx_op_e  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] y
);
  import dsx_pkg::*;

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_LDI:  y = imm;
      OP_PASS: y = a;
      OP_NOR:  y = ~(a | b);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/dual_stage_exec.sv
module dual_stage_exec #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int CNT_W  = 16,
  parameter int BYPASS = 1,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [AW-1:0]     in_dst,
  input  logic [AW-1:0]     in_src_a,
  input  logic [AW-1:0]     in_src_b,
  input  logic [DATA_W-1:0] in_imm,
  output logic              wb_valid,
  output logic [AW-1:0]     wb_dst,
  output logic [DATA_W-1:0] wb_data,
  output logic [CNT_W-1:0]  stall_count
);
  import dsx_pkg::*;

  localparam bit USE_FWD = (BYPASS != 0);

  typedef struct packed {
    logic              valid;
    dsx_op_e           op;
    logic [AW-1:0]     dst;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
    logic [DATA_W-1:0] imm;
  } exec_slot_t;

  exec_slot_t        s2_q;
  logic [AW-1:0]     rd_addr [2];
  logic [DATA_W-1:0] rd_data [2];
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] opnd_a, opnd_b;
  logic              hit_a, hit_b, stall;
  logic              take;

  assign rd_addr[0] = in_src_a;
  assign rd_addr[1] = in_src_b;

  dsx_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (s2_q.valid),
    .wr_addr (s2_q.dst),
    .wr_data (alu_y)
  );

  dsx_hazard #(.NREG(NREG), .BYPASS(BYPASS)) u_hz (
    .in_valid (in_valid),
    .in_op    (in_op),
    .src_a    (in_src_a),
    .src_b    (in_src_b),
    .s2_valid (s2_q.valid),
    .s2_dst   (s2_q.dst),
    .hit_a    (hit_a),
    .hit_b    (hit_b),
    .stall    (stall)
  );

  dsx_alu #(.DATA_W(DATA_W)) u_alu (
    .op  (s2_q.op),
    .a   (s2_q.a),
    .b   (s2_q.b),
    .imm (s2_q.imm),
    .y   (alu_y)
  );

  // operand select: stage-2 result replaces a stale register read
  assign opnd_a = (USE_FWD && hit_a) ? alu_y : rd_data[0];
  assign opnd_b = (USE_FWD && hit_b) ? alu_y : rd_data[1];

  assign in_ready = !stall;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_q <= '0;
    end else begin
      s2_q.valid <= take;
      if (take) begin
        s2_q.op  <= dsx_op_e'(in_op);
        s2_q.dst <= in_dst;
        s2_q.a   <= opnd_a;
        s2_q.b   <= opnd_b;
        s2_q.imm <= in_imm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  stall_count <= '0;
    else if (in_valid && !in_ready) stall_count <= stall_count + 1'b1;
  end

  assign wb_valid = s2_q.valid;
  assign wb_dst   = s2_q.dst;
  assign wb_data  = alu_y;

endmodule

// File: rtl/dsx_checker.sv
module dsx_checker #(
  parameter int NREG   = 8,
  parameter int CNT_W  = 16,
  parameter int BYPASS = 1,
  localparam int AW    = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [AW-1:0]    in_dst,
  input logic             wb_valid,
  input logic [AW-1:0]    wb_dst,
  input logic [CNT_W-1:0] stall_count
);
  import dsx_pkg::*;

  AST_ACCEPT_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> wb_valid); // R3

  AST_WB_DST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (wb_dst == $past(in_dst))); // R3

  AST_BUBBLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !wb_valid); // R8

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> in_ready); // R6

  AST_FWD_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_ready || (BYPASS == 0))); // R5

  AST_LDI_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == 3'(OP_LDI))) |-> in_ready); // R9

  AST_STALL_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (stall_count == CNT_W'($past(stall_count) + 1'b1))); // R7

  AST_STALL_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !in_ready) |=> $stable(stall_count)); // R7

endmodule

bind dual_stage_exec dsx_checker #(.NREG(NREG), .CNT_W(CNT_W), .BYPASS(BYPASS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_dst      (in_dst),
  .wb_valid    (wb_valid),
  .wb_dst      (wb_dst),
  .stall_count (stall_count)
);

// File: tb/dual_stage_exec_test.sv
`timescale 1ns/1ps
module dual_stage_exec_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        v    [2];
  logic        rdy  [2];
  logic [2:0]  op   [2];
  logic [2:0]  dst  [2];
  logic [2:0]  sa   [2];
  logic [2:0]  sb   [2];
  logic [15:0] imm  [2];
  logic        wv   [2];
  logic [2:0]  wd   [2];
  logic [15:0] wdat [2];
  logic [15:0] sc   [2];

  // instance 0: forwarding variant, instance 1: interlock variant
  dual_stage_exec #(.DATA_W(16), .NREG(8), .CNT_W(16), .BYPASS(1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(v[0]), .in_ready(rdy[0]), .in_op(op[0]),
    .in_dst(dst[0]), .in_src_a(sa[0]), .in_src_b(sb[0]), .in_imm(imm[0]),
    .wb_valid(wv[0]), .wb_dst(wd[0]), .wb_data(wdat[0]), .stall_count(sc[0]));

  dual_stage_exec #(.DATA_W(16), .NREG(8), .CNT_W(16), .BYPASS(0)) uut_lk (
    .clk(clk), .rst_n(rst_n), .in_valid(v[1]), .in_ready(rdy[1]), .in_op(op[1]),
    .in_dst(dst[1]), .in_src_a(sa[1]), .in_src_b(sb[1]), .in_imm(imm[1]),
    .wb_valid(wv[1]), .wb_dst(wd[1]), .wb_data(wdat[1]), .stall_count(sc[1]));

  typedef struct {
    logic [2:0]  dst;
    logic [15:0] data;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t        q0 [$];
  exp_t        q1 [$];
  logic [15:0] model [2][8];
  int          prev_c [2];
  logic [2:0]  prev_d [2];
  int          exp_stalls [2];
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_alu(input logic [2:0] o, input logic [15:0] a,
                                          input logic [15:0] b, input logic [15:0] im);
    case (o)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return im;
      3'd6: return a;
      default: return ~(a | b);
    endcase
  endfunction

  // driver: presents one instruction, waits out any stall, pushes the expectation
  task automatic issue(input int m, input logic [2:0] o, input logic [2:0] d,
                       input logic [2:0] a, input logic [2:0] b,
                       input logic [15:0] im, input string tag);
    int c0, stalls, exp_st;
    bit dep, ua, ub;
    exp_t e;
    @(negedge clk);
    v[0] = 1'b0; v[1] = 1'b0;
    op[m] = o; dst[m] = d; sa[m] = a; sb[m] = b; imm[m] = im; v[m] = 1'b1;
    #1;
    c0 = cyc;
    stalls = 0;
    while (!rdy[m]) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    ua = (o != 3'd5);
    ub = (o != 3'd5) && (o != 3'd6);
    dep = (c0 == prev_c[m] + 1) && ((ua && a == prev_d[m]) || (ub && b == prev_d[m]));
    exp_st = (m == 1 && dep) ? 1 : 0;
    chk(stalls == exp_st, (m == 1) ? "R6" : "R5", "stall cycles for instruction", stalls, exp_st);
    exp_stalls[m] += exp_st;
    e.dst  = d;
    e.data = ref_alu(o, model[m][a], model[m][b], im);
    e.cyc  = cyc + 1;
    e.tag  = (stalls > 0) ? "R10" : tag;
    model[m][d] = e.data;
    if (m == 0) q0.push_back(e); else q1.push_back(e);
    prev_c[m] = cyc;
    prev_d[m] = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      v[0] = 1'b0; v[1] = 1'b0;
    end
  endtask

  // monitor: pops and compares write-back items
  task automatic mon(input int m);
    exp_t e;
    if (!wv[m]) return;
    if ((m == 0 && q0.size() == 0) || (m == 1 && q1.size() == 0)) begin
      chk(1'b0, "R8", "write-back with nothing accepted", wd[m], 0);
      return;
    end
    e = (m == 0) ? q0.pop_front() : q1.pop_front();
    chk(wd[m] == e.dst, e.tag, "write-back register", wd[m], e.dst);
    chk(wdat[m] == e.data, e.tag, "write-back data", wdat[m], e.data);
    chk(cyc == e.cyc, "R3", "write-back cycle", cyc, e.cyc);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      mon(0);
      mon(1);
    end
  end

  task automatic run_mode(input int m);
    string dt;
    dt = (m == 1) ? "R6" : "R5";
    // R1: every register reads zero after reset
    for (int r = 0; r < 8; r++) issue(m, 3'd6, 3'(r), 3'(r), 3'(r), 16'h0, "R1");
    // R9: immediate loads whose unused source fields alias the previous destination
    for (int r = 0; r < 8; r++)
      issue(m, 3'd5, 3'(r), 3'((r + 7) % 8), 3'((r + 7) % 8), 16'(16'h1357 * (r + 1)), "R9");
    // R2: all codes, back to back, no conflicts
    issue(m, 3'd0, 3'd0, 3'd1, 3'd2, 16'h0, "R2");
    issue(m, 3'd1, 3'd3, 3'd4, 3'd5, 16'h0, "R2");
    issue(m, 3'd2, 3'd6, 3'd1, 3'd7, 16'h0, "R2");
    issue(m, 3'd3, 3'd2, 3'd4, 3'd5, 16'h0, "R2");
    issue(m, 3'd4, 3'd1, 3'd3, 3'd7, 16'h0, "R2");
    issue(m, 3'd7, 3'd5, 3'd7, 3'd6, 16'h0, "R2");
    issue(m, 3'd6, 3'd4, 3'd3, 3'd4, 16'h0, "R2");
    issue(m, 3'd5, 3'd7, 3'd0, 3'd0, 16'hFFFF, "R2");
    // dependent on A, then B, then both, then a self-chain
    issue(m, 3'd0, 3'd3, 3'd1, 3'd2, 16'h0, "R2");
    issue(m, 3'd1, 3'd4, 3'd3, 3'd1, 16'h0, dt);
    issue(m, 3'd2, 3'd5, 3'd6, 3'd4, 16'h0, dt);
    issue(m, 3'd4, 3'd5, 3'd5, 3'd5, 16'h0, dt);
    issue(m, 3'd0, 3'd5, 3'd5, 3'd1, 16'h0, dt);
    issue(m, 3'd0, 3'd5, 3'd5, 3'd1, 16'h0, dt);
    issue(m, 3'd0, 3'd5, 3'd5, 3'd1, 16'h0, dt);
    // R9: copy ignores B even when B names the producer
    issue(m, 3'd6, 3'd6, 3'd2, 3'd5, 16'h0, "R9");
    // R4: distance-two dependency
    issue(m, 3'd0, 3'd0, 3'd1, 3'd2, 16'h0, "R4");
    issue(m, 3'd3, 3'd7, 3'd3, 3'd4, 16'h0, "R4");
    issue(m, 3'd2, 3'd1, 3'd0, 3'd3, 16'h0, "R4");
    // R8: bubble between producer and consumer
    idle(1);
    issue(m, 3'd0, 3'd2, 3'd1, 3'd1, 16'h0, "R8");
    idle(1);
    issue(m, 3'd1, 3'd3, 3'd2, 3'd1, 16'h0, "R8");
    idle(3);
    chk(sc[m] == 16'(exp_stalls[m]), "R7", "stall counter", sc[m], exp_stalls[m]);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      v[m] = 1'b0; op[m] = '0; dst[m] = '0; sa[m] = '0; sb[m] = '0; imm[m] = '0;
      prev_c[m] = -10; prev_d[m] = '0; exp_stalls[m] = 0;
      for (int r = 0; r < 8; r++) model[m][r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    for (int m = 0; m < 2; m++) begin
      chk(rdy[m] == 1'b1, "R1", "ready after reset", rdy[m], 1);
      chk(wv[m] == 1'b0, "R1", "write-back valid after reset", wv[m], 0);
      chk(sc[m] == 16'h0, "R1", "stall counter after reset", sc[m], 0);
    end
    run_mode(0);
    run_mode(1);
    chk(sc[0] == 16'h0, "R7", "forwarding variant never stalls", sc[0], 0);
    chk(exp_stalls[1] == 6, "R6", "interlock stalls in program", exp_stalls[1], 6);
    idle(4);
    chk(q0.size() == 0, "R3", "pending results forwarding", q0.size(), 0);
    chk(q1.size() == 0, "R3", "pending results interlock", q1.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule